// File: doc/BRIEF.md
# Multi-Source Reset Sequencing Controller

This block gathers reset requests from a backplane reset line, a three-stage watchdog, a power-good monitor and a small software register file. It turns them into four reset outputs, each with its own scope: a processor-only external reset (XIR), a system-wide power-on reset (POR), a power-ok level toward the reset interface, and a reset driven out onto the backplane. Every output pulse lasts a fixed number of cycles. A pulse restarts when a new request arrives while it is still active.

Two straps, each two bits wide, decide whether the backplane may reset this board and whether a local POR is passed on to the backplane. Software can start a POR or an XIR by setting sticky request bits. Those bits survive the reset they cause, so the cause can be read afterwards. Software can also pulse the backplane reset alone, without touching anything local. The request bits are cleared only by an explicit clear write or by a cold power-up reset.

Top module: `rstseq_top`

## Requirements
- R1: With the input strap at 2'b01, a high level on `bp_rst_in` passes through a two-flop synchronizer. It raises `por_out` and drops `pwr_ok` starting at the third clock edge after the level is set up.
- R2: With the input strap at 2'b10, 2'b00 (open) or 2'b11, `bp_rst_in` has no effect on any output.
- R3: A POR request also pulses `bp_rst_out` only when the output strap is 2'b01. At any other strap value `bp_rst_out` stays low during a POR.
- R4: A write to address 2 with `reg_wdata[0]`=1 pulses `bp_rst_out` alone. `por_out` and `xir_out` stay low and `pwr_ok` stays high.
- R5: `wdog2` asserts `xir_out` at the next edge. It never raises `por_out` or `bp_rst_out`, and `pwr_ok` stays high.
- R6: `wdog3` asserts `por_out` and drops `pwr_ok` at the next edge.
- R7: A low `pwr_good` starts the same POR sequence as `wdog3`.
- R8: A write to address 0 sets request bits where `reg_wdata` is 1: bit 0 is the software POR request and bit 1 is the software XIR request. Each such write fires the matching reset. `reg_rdata` shows both bits.
- R9: The request bits stay set through the reset they cause and through `rst`. They clear only by a write to address 1 (a 1 clears that bit) or by `cold_rst`.
- R10: Every output pulse is exactly PULSE_W (16) cycles long. A request that arrives while the pulse is active restarts the full width.
- R11: When a POR and an XIR request arrive in the same cycle, or an XIR request arrives during an active POR, the XIR request is dropped.
- R12: `pwr_ok` is low exactly while `por_out` is high.
- R13: After reset all reset outputs are low, `pwr_ok` is high and `reg_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous warm reset, active high; leaves request bits alone |
| cold_rst | input | 1 | Synchronous power-up reset, active high; clears everything |
| bp_rst_in | input | 1 | Asynchronous backplane reset request, active high |
| strap_in | input | 2 | Backplane-in enable strap (2'b01 enables) |
| strap_out | input | 2 | Backplane-out enable strap (2'b01 enables) |
| wdog2 | input | 1 | Second watchdog stage expired |
| wdog3 | input | 1 | Third watchdog stage expired |
| pwr_good | input | 1 | Power monitor good, low requests POR |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 set, 1 clear, 2 backplane pulse |
| reg_wdata | input | 2 | Register write data |
| reg_rdata | output | 2 | Request bits {xir, por} |
| xir_out | output | 1 | Processor-only external reset |
| por_out | output | 1 | System-wide power-on reset |
| pwr_ok | output | 1 | Power-ok toward reset interface |
| bp_rst_out | output | 1 | Reset driven onto backplane |

## Verification
Each reset source is fired on its own, and the bench checks that only the outputs in that source's scope move: watchdog stage 2 against stage 3, the software backplane pulse against a local POR. The straps are stepped through all positions, which separates honoured requests from blocked ones in both directions. Coinciding and overlapping requests expose the POR-over-XIR priority and the pulse restart. Register writes followed by warm and cold resets separate sticky bits from bits that a reset clears.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
  typedef enum logic [1:0] {
    STRAP_OPEN = 2'b00,
    STRAP_ON   = 2'b01,
    STRAP_OFF  = 2'b10
  } strap_e;

  localparam int NCH    = 3;
  localparam int CH_POR = 0;
  localparam int CH_XIR = 1;
  localparam int CH_BP  = 2;

  localparam logic [1:0] ADDR_SET  = 2'd0;
  localparam logic [1:0] ADDR_CLR  = 2'd1;
  localparam logic [1:0] ADDR_BPRS = 2'd2;

  localparam int REQ_POR_BIT = 0;
  localparam int REQ_XIR_BIT = 1;
endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-2:0], din};
  end

  assign dout = sh[STAGES-1];
endmodule

// File: rtl/rstseq_pulse.sv
module rstseq_pulse #(
  parameter int WIDTH = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  output logic active,
  output logic active_next
);
  localparam int CNT_W = $clog2(WIDTH + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (req)        cnt <= CNT_W'(WIDTH);
    else if (cnt != '0)  cnt <= cnt - CNT_W'(1);
  end

  assign active      = (cnt != '0);
  assign active_next = req | (cnt > CNT_W'(1));
endmodule

// File: rtl/rstseq_regs.sv
module rstseq_regs
  import rstseq_pkg::*;
(
  input  logic       clk,
  input  logic       cold_rst,
  input  logic       wr,
  input  logic [1:0] addr,
  input  logic [1:0] wdata,
  output logic [1:0] bits,
  output logic       sw_por_trig,
  output logic       sw_xir_trig,
  output logic       sw_bp_trig
);
  logic wr_set, wr_clr, wr_bp;

  assign wr_set = wr && (addr == ADDR_SET);
  assign wr_clr = wr && (addr == ADDR_CLR);
  assign wr_bp  = wr && (addr == ADDR_BPRS);

  always_ff @(posedge clk) begin
    if (cold_rst)    bits <= '0;
    else if (wr_set) bits <= bits | wdata;
    else if (wr_clr) bits <= bits & ~wdata;
  end

  assign sw_por_trig = wr_set && wdata[REQ_POR_BIT];
  assign sw_xir_trig = wr_set && wdata[REQ_XIR_BIT];
  assign sw_bp_trig  = wr_bp  && wdata[0];
endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
  import rstseq_pkg::*;
#(
  parameter int PULSE_W     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cold_rst,
  input  logic       bp_rst_in,
  input  logic [1:0] strap_in,
  input  logic [1:0] strap_out,
  input  logic       wdog2,
  input  logic       wdog3,
  input  logic       pwr_good,
  input  logic       reg_wr,
  input  logic [1:0] reg_addr,
  input  logic [1:0] reg_wdata,
  output logic [1:0] reg_rdata,
  output logic       xir_out,
  output logic       por_out,
  output logic       pwr_ok,
  output logic       bp_rst_out
);
  logic any_rst;
  logic bp_sync;
  logic in_ok, out_ok;
  logic sw_por_trig, sw_xir_trig, sw_bp_trig;
  logic por_req;
  logic [NCH-1:0] ch_req, ch_act, ch_next;
  logic pwr_ok_q;

  assign any_rst = rst | cold_rst;

  rstseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (any_rst),
    .din  (bp_rst_in),
    .dout (bp_sync)
  );

  rstseq_regs u_regs (
    .clk         (clk),
    .cold_rst    (cold_rst),
    .wr          (reg_wr),
    .addr        (reg_addr),
    .wdata       (reg_wdata),
    .bits        (reg_rdata),
    .sw_por_trig (sw_por_trig),
    .sw_xir_trig (sw_xir_trig),
    .sw_bp_trig  (sw_bp_trig)
  );

  assign in_ok  = (strap_in  == STRAP_ON);
  assign out_ok = (strap_out == STRAP_ON);

  // system-wide sources
  assign por_req = wdog3 | sw_por_trig | ~pwr_good | (bp_sync & in_ok);

  assign ch_req[CH_POR] = por_req;
  // processor-only: dropped when a POR is requested or running
  assign ch_req[CH_XIR] = (wdog2 | sw_xir_trig) & ~por_req & ~ch_act[CH_POR];
  // backplane: software pulse or strapped POR propagation
  assign ch_req[CH_BP]  = sw_bp_trig | (por_req & out_ok);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    rstseq_pulse #(.WIDTH(PULSE_W)) u_pulse (
      .clk         (clk),
      .rst         (any_rst),
      .req         (ch_req[g]),
      .active      (ch_act[g]),
      .active_next (ch_next[g])
    );
  end

  always_ff @(posedge clk) begin
    if (any_rst) pwr_ok_q <= 1'b1;
    else         pwr_ok_q <= ~ch_next[CH_POR];
  end

  assign por_out    = ch_act[CH_POR];
  assign xir_out    = ch_act[CH_XIR];
  assign bp_rst_out = ch_act[CH_BP];
  assign pwr_ok     = pwr_ok_q;
endmodule

// File: rtl/rstseq_top_chk.sv
module rstseq_top_chk #(
  parameter int PULSE_W = 16
) (
  input logic       clk,
  input logic       rst,
  input logic       cold_rst,
  input logic       wdog2,
  input logic       wdog3,
  input logic       por_req,
  input logic       out_ok,
  input logic       sw_bp_trig,
  input logic       reg_wr,
  input logic [1:0] reg_addr,
  input logic [1:0] reg_wdata,
  input logic [1:0] reg_rdata,
  input logic       xir_out,
  input logic       por_out,
  input logic       pwr_ok,
  input logic       bp_rst_out
);
  localparam int RW = $clog2(PULSE_W + 1) + 1;
  logic [RW-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst || cold_rst) run_cnt <= '0;
    else if (por_out)    run_cnt <= (run_cnt >= RW'(PULSE_W)) ? run_cnt : run_cnt + RW'(1);
    else                 run_cnt <= '0;
  end

  p_pwr_ok_track_r12: assert property (@(posedge clk) disable iff (rst || cold_rst)
    pwr_ok == !por_out);

  p_por_width_r10: assert property (@(posedge clk) disable iff (rst || cold_rst)
    ($fell(por_out) && !$past(rst || cold_rst)) |-> (run_cnt >= RW'(PULSE_W)));

  p_wd3_por_r6: assert property (@(posedge clk) disable iff (rst || cold_rst)
    $past(wdog3 && !rst && !cold_rst) |-> por_out);

  p_wd2_xir_r5: assert property (@(posedge clk) disable iff (rst || cold_rst)
    $past(wdog2 && !por_req && !por_out && !rst && !cold_rst) |-> xir_out);

  p_xir_local_r11: assert property (@(posedge clk) disable iff (rst || cold_rst)
    $rose(xir_out) |-> !por_out);

  p_bp_out_src_r3: assert property (@(posedge clk) disable iff (rst || cold_rst)
    $rose(bp_rst_out) |-> $past(sw_bp_trig || (por_req && out_ok)));

  p_sticky_por_r9: assert property (@(posedge clk) disable iff (cold_rst)
    $past(reg_rdata[0] && !cold_rst && !(reg_wr && reg_addr == 2'd1 && reg_wdata[0]))
      |-> reg_rdata[0]);
endmodule

bind rstseq_top rstseq_top_chk #(.PULSE_W(PULSE_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cold_rst   (cold_rst),
  .wdog2      (wdog2),
  .wdog3      (wdog3),
  .por_req    (por_req),
  .out_ok     (out_ok),
  .sw_bp_trig (sw_bp_trig),
  .reg_wr     (reg_wr),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .reg_rdata  (reg_rdata),
  .xir_out    (xir_out),
  .por_out    (por_out),
  .pwr_ok     (pwr_ok),
  .bp_rst_out (bp_rst_out)
);

// File: tb/rstseq_top_test.sv
module rstseq_top_test;
  logic       clk = 1'b0;
  logic       rst, cold_rst, bp_rst_in, wdog2, wdog3, pwr_good, reg_wr;
  logic [1:0] strap_in, strap_out, reg_addr, reg_wdata, reg_rdata;
  logic       xir_out, por_out, pwr_ok, bp_rst_out;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct {
    string      tag;
    bit         por;
    bit         xir;
    bit         bp;
    bit         pok;
    logic [1:0] rd;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  rstseq_top uut (
    .clk(clk), .rst(rst), .cold_rst(cold_rst), .bp_rst_in(bp_rst_in),
    .strap_in(strap_in), .strap_out(strap_out), .wdog2(wdog2), .wdog3(wdog3),
    .pwr_good(pwr_good), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xir_out(xir_out),
    .por_out(por_out), .pwr_ok(pwr_ok), .bp_rst_out(bp_rst_out)
  );

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_out(string tag, bit por, bit xir, bit bp, bit pok, logic [1:0] rd);
    exp_t e;
    e.tag = tag; e.por = por; e.xir = xir; e.bp = bp; e.pok = pok; e.rd = rd;
    q.push_back(e);
  endtask

  task automatic idle(string tag, logic [1:0] rd);
    expect_out(tag, 1'b0, 1'b0, 1'b0, 1'b1, rd);
  endtask

  task automatic pulse_wd(bit w2, bit w3);
    wdog2 = w2; wdog3 = w3;
    step(1);
    wdog2 = 1'b0; wdog3 = 1'b0;
  endtask

  task automatic reg_write(logic [1:0] a, logic [1:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    step(1);
    reg_wr = 1'b0; reg_wdata = 2'b00;
  endtask

  task automatic bp_in_blocked(logic [1:0] s, string tag);
    strap_in = s;
    bp_rst_in = 1'b1;
    step(1);
    bp_rst_in = 1'b0;
    step(4);
    idle(tag, 2'b00);
  endtask

  // monitor: compares queued expectations shortly after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (por_out !== e.por || xir_out !== e.xir || bp_rst_out !== e.bp ||
            pwr_ok !== e.pok || reg_rdata !== e.rd) begin
          errors++;
          $display("FAIL %s: got por=%b xir=%b bp=%b pok=%b rd=%b exp por=%b xir=%b bp=%b pok=%b rd=%b",
                   e.tag, por_out, xir_out, bp_rst_out, pwr_ok, reg_rdata,
                   e.por, e.xir, e.bp, e.pok, e.rd);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; cold_rst = 1'b1; bp_rst_in = 1'b0; wdog2 = 1'b0; wdog3 = 1'b0;
    pwr_good = 1'b1; reg_wr = 1'b0; reg_addr = 2'b00; reg_wdata = 2'b00;
    strap_in = 2'b00; strap_out = 2'b00;
    step(3);
    rst = 1'b0; cold_rst = 1'b0;
    step(1);
    idle("R13 reset state", 2'b00);

    // R6 / R10: stage-3 watchdog, open out strap
    pulse_wd(1'b0, 1'b1);
    expect_out("R6 wdog3 por", 1, 0, 0, 0, 2'b00);
    step(15);
    expect_out("R10 last cycle", 1, 0, 0, 0, 2'b00);
    step(1);
    idle("R10 pulse end", 2'b00);

    // R3: out strap on, then off
    strap_out = 2'b01;
    pulse_wd(1'b0, 1'b1);
    expect_out("R3 propagate on", 1, 0, 1, 0, 2'b00);
    step(16);
    idle("R3 end", 2'b00);
    strap_out = 2'b10;
    pulse_wd(1'b0, 1'b1);
    expect_out("R3 blocked off", 1, 0, 0, 0, 2'b00);
    step(16);
    idle("R3 end off", 2'b00);

    // R5: stage-2 watchdog, out strap on
    strap_out = 2'b01;
    pulse_wd(1'b1, 1'b0);
    expect_out("R5 wdog2 xir only", 0, 1, 0, 1, 2'b00);
    step(15);
    expect_out("R10 xir last", 0, 1, 0, 1, 2'b00);
    step(1);
    idle("R5 end", 2'b00);

    // R11: coincident, then xir during active por
    pulse_wd(1'b1, 1'b1);
    expect_out("R11 coincident", 1, 0, 1, 0, 2'b00);
    step(16);
    idle("R11 end", 2'b00);
    pulse_wd(1'b0, 1'b1);
    step(3);
    pulse_wd(1'b1, 1'b0);
    expect_out("R11 xir during por", 1, 0, 1, 0, 2'b00);
    step(12);
    idle("R11 no late xir", 2'b00);

    // R10 retrigger
    pulse_wd(1'b0, 1'b1);
    step(9);
    pulse_wd(1'b0, 1'b1);
    step(15);
    expect_out("R10 retrigger held", 1, 0, 1, 0, 2'b00);
    step(1);
    idle("R10 retrigger end", 2'b00);
    strap_out = 2'b00;

    // R1: backplane in enabled
    strap_in = 2'b01;
    bp_rst_in = 1'b1;
    step(1);
    bp_rst_in = 1'b0;
    idle("R1 sync stage1", 2'b00);
    step(1);
    idle("R1 sync stage2", 2'b00);
    step(1);
    expect_out("R1 bp in por", 1, 0, 0, 0, 2'b00);
    step(16);
    idle("R1 end", 2'b00);

    // R2: blocked strap positions
    bp_in_blocked(2'b10, "R2 strap off");
    bp_in_blocked(2'b00, "R2 strap open");
    bp_in_blocked(2'b11, "R2 strap 11");

    // R7: power-good low
    pwr_good = 1'b0;
    step(1);
    pwr_good = 1'b1;
    expect_out("R7 pwr_good por", 1, 0, 0, 0, 2'b00);
    step(16);
    idle("R7 end", 2'b00);

    // R8 / R9: software POR
    reg_write(2'd0, 2'b01);
    expect_out("R8 sw por", 1, 0, 0, 0, 2'b01);
    step(16);
    idle("R9 sticky after por", 2'b01);
    rst = 1'b1;
    step(2);
    rst = 1'b0;
    step(1);
    idle("R9 sticky after warm rst", 2'b01);
    reg_write(2'd1, 2'b01);
    idle("R9 clear write", 2'b00);

    // R8: software XIR
    reg_write(2'd0, 2'b10);
    expect_out("R8 sw xir", 0, 1, 0, 1, 2'b10);
    step(16);
    idle("R9 sticky after xir", 2'b10);

    // R11: both bits at once
    reg_write(2'd0, 2'b11);
    expect_out("R11 sw both", 1, 0, 0, 0, 2'b11);
    step(16);
    idle("R11 sw both end", 2'b11);

    // R9: cold reset clears bits
    cold_rst = 1'b1;
    step(1);
    cold_rst = 1'b0;
    idle("R9 cold clears", 2'b00);

    // R4: software backplane pulse, with local straps on too
    strap_in = 2'b01; strap_out = 2'b01;
    reg_write(2'd2, 2'b01);
    expect_out("R4 sw bp only", 0, 0, 1, 1, 2'b00);
    step(15);
    expect_out("R4 bp last", 0, 0, 1, 1, 2'b00);
    step(1);
    idle("R4 end", 2'b00);

    step(2);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule